// File: doc/BRIEF.md
# Prescaled Tick Timer

The block produces a periodic tick interrupt from a 32768 Hz reference strobe. A free-running 15-bit prescaler counts reference strobes and, depending on a 4-bit divider select N, passes one strobe in every 2^N to a down-counter. While the timer runs, the down-counter steps once per divided pulse. When it expires it reloads from a software reload register and keeps running. Each expiry sets a sticky status flag, which drives the tick interrupt line until software clears it by writing a one.

Software uses a small word-wide register port with four locations. Location 0 is control: the divider select in bits [7:4] and the tick-enable in bit 8. Location 1 is the reload value. Location 2 is status, with the flag in bit 0 and write-one-to-clear behaviour. Location 3 is the live down-count and is read-only. Reads are combinational from `addr`. A write takes effect at the clock edge that samples `wr_en`. A separate `rtc_en` input is the global enable. When it is low, the prescaler and the timer both stop.

Top module: `ptick_timer`

## Requirements
- R1: After reset, every readable location returns 0, the timer is stopped and both `tick_irq` and `tick_status` are low.
- R2: The prescaler advances on each `ref_stb` while `rtc_en` is high. A divided pulse occurs on every 2^N-th strobe, where N is control bits [7:4] (N=0 means every strobe).
- R3: A write to location 1 stores the value only if it is greater than 2. Any other write leaves the reload register unchanged.
- R4: The timer loads the reload value into the down-counter and starts only on a control write that changes bit 8 from 0 to 1 while `rtc_en` is high and the reload register is nonzero.
- R5: While running, each divided pulse decrements the count. A pulse at count 1 is an expiry: the count reloads from the reload register and counting continues, so expiries are spaced reload × 2^N strobes apart.
- R6: An expiry sets the status flag, and `tick_irq` is high exactly while the flag is set.
- R7: Writing location 2 with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R8: If a clearing write and an expiry fall in the same cycle, the flag ends up set.
- R9: A control write that changes bit 8 from 1 to 0 while `rtc_en` is high stops the timer, and the count holds its value.
- R10: When `rtc_en` is low, the prescaler clears and the timer stops. Raising `rtc_en` again does not restart the timer without a fresh 0-to-1 edge of bit 8.
- R11: Reading location 3 returns the live down-counter value in every cycle.
- R12: Reading location 0 returns bit 8 and bits [7:4] as last written. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_en | input | 1 | Global enable; low halts the prescaler and timer |
| ref_stb | input | 1 | One-cycle strobe at the 32768 Hz reference rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register location (0 control, 1 reload, 2 status, 3 count) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| tick_irq | output | 1 | Tick interrupt, level |
| tick_status | output | 1 | Sticky tick status flag |

## Verification
The assertions assume the following about the inputs:
- `rtc_en`, `ref_stb` and the register port are synchronous to `clk`.
- At most one register write occurs per cycle.
- `ref_stb` may be high in any pattern, including every cycle.

The bench changes all inputs only on the falling edge. It mostly holds `ref_stb` high on every cycle, so the divided rate is exactly 2^N clocks. To reach the expiry-versus-clear collision, the bench's own reference model supplies the cycle in which the count is 1. The bench issues the write in exactly that cycle, so stimulus never relies on assumptions the properties do not make.

// File: rtl/ptick_pkg.sv
package ptick_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_STATUS = 2'd2,
    REG_COUNT  = 2'd3
  } ptick_reg_e;

  localparam int unsigned SEL_W        = 4;
  localparam int unsigned SEL_LSB      = 4;
  localparam int unsigned TEN_BIT      = 8;
  localparam int unsigned STAT_BIT     = 0;
  localparam int unsigned RELOAD_FLOOR = 2;

endpackage

// File: rtl/ptick_prescaler.sv
module ptick_prescaler
  import ptick_pkg::*;
#(
  parameter int unsigned PRESC_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_en,
  input  logic             ref_stb,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [PRESC_W-1:0] presc_q;
  logic [PRESC_W-1:0] presc_d;
  logic               presc_en;
  logic [PRESC_W-1:0] mask;

  // Low sel_i bits of the mask are ones: terminal count every 2^sel strobes.
  for (genvar g = 0; g < PRESC_W; g++) begin : g_mask
    assign mask[g] = (32'(g) < 32'(sel_i));
  end

  always_comb begin
    presc_en = !rtc_en || ref_stb;
    presc_d  = presc_q;
    if (!rtc_en) begin
      presc_d = '0;
    end else if (ref_stb) begin
      presc_d = presc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
    end else if (presc_en) begin
      presc_q <= presc_d;
    end
  end

  assign tick_o = rtc_en && ref_stb && ((presc_q & mask) == mask);

  assert_presc_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_en |=> (presc_q == '0));

  assert_presc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_en && ref_stb) |=> (presc_q == PRESC_W'($past(presc_q) + 1'b1)));

  assert_presc_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_en && !ref_stb) |=> $stable(presc_q));

endmodule

// File: rtl/ptick_regs.sv
module ptick_regs
  import ptick_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_en,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              status_o,
  output logic              start_o,
  output logic              stop_o,
  output logic [DATA_W-1:0] ctrl_rd_o
);

  logic             wr_ctrl, wr_reload, wr_stat;
  logic             ten_q, ten_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             reload_en;
  logic             status_q, status_d;
  logic             new_ten;

  always_comb begin
    wr_ctrl   = wr_en && (addr == REG_CTRL);
    wr_reload = wr_en && (addr == REG_RELOAD);
    wr_stat   = wr_en && (addr == REG_STATUS);
    new_ten   = wdata[TEN_BIT];

    ten_d = wr_ctrl ? new_ten : ten_q;
    sel_d = wr_ctrl ? wdata[SEL_LSB +: SEL_W] : sel_q;

    reload_en = wr_reload && (wdata[CNT_W-1:0] > CNT_W'(RELOAD_FLOOR));
    reload_d  = wdata[CNT_W-1:0];

    if (expire_i) begin
      status_d = 1'b1;
    end else if (wr_stat && wdata[STAT_BIT]) begin
      status_d = 1'b0;
    end else begin
      status_d = status_q;
    end

    start_o = wr_ctrl && new_ten && !ten_q && rtc_en && (reload_q != '0);
    stop_o  = wr_ctrl && !new_ten && ten_q && rtc_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten_q <= 1'b0;
      sel_q <= '0;
    end else if (wr_ctrl) begin
      ten_q <= ten_d;
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (reload_en) begin
      reload_q <= reload_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else begin
      status_q <= status_d;
    end
  end

  always_comb begin
    ctrl_rd_o                     = '0;
    ctrl_rd_o[TEN_BIT]            = ten_q;
    ctrl_rd_o[SEL_LSB +: SEL_W]   = sel_q;
  end

  assign sel_o    = sel_q;
  assign reload_o = reload_q;
  assign status_o = status_q;

  assert_reload_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q != '0) |-> (reload_q > CNT_W'(RELOAD_FLOOR)));

  assert_small_reload_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reload && (wdata <= DATA_W'(RELOAD_FLOOR))) |=> $stable(reload_q));

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[STAT_BIT] && !expire_i) |=> !status_q);

  assert_w0_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wdata[STAT_BIT] && status_q) |=> status_q);

  assert_expiry_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> status_q);

endmodule

// File: rtl/ptick_downcount.sv
module ptick_downcount #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_en,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             run_q, run_d;
  logic             step;
  logic             at_one;

  always_comb begin
    step     = run_q && tick_i;
    at_one   = (cnt_q == CNT_W'(1));
    expire_o = step && at_one;

    cnt_en = start_i || step;
    if (start_i || at_one) begin
      cnt_d = reload_i;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end

    if (!rtc_en) begin
      run_d = 1'b0;
    end else if (start_i) begin
      run_d = 1'b1;
    end else if (stop_i) begin
      run_d = 1'b0;
    end else begin
      run_d = run_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  assign cnt_o = cnt_q;

  assert_start_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (run_q && (cnt_q == $past(reload_i))));

  assert_expire_reloads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == $past(reload_i)));

  assert_running_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));

  assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i) |=> $stable(cnt_q));

  assert_stop_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !run_q);

  assert_global_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_en |=> !run_q);

endmodule

// File: rtl/ptick_timer.sv
module ptick_timer
  import ptick_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRESC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_en,
  input  logic              ref_stb,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tick_irq,
  output logic              tick_status
);

  logic [SEL_W-1:0]  sel;
  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] ctrl_rd;
  logic              status;
  logic              start, stop, tick, expire;

  ptick_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .rtc_en  (rtc_en),
    .ref_stb (ref_stb),
    .sel_i   (sel),
    .tick_o  (tick)
  );

  ptick_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rtc_en    (rtc_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .expire_i  (expire),
    .sel_o     (sel),
    .reload_o  (reload),
    .status_o  (status),
    .start_o   (start),
    .stop_o    (stop),
    .ctrl_rd_o (ctrl_rd)
  );

  ptick_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rtc_en   (rtc_en),
    .tick_i   (tick),
    .start_i  (start),
    .stop_i   (stop),
    .reload_i (reload),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  always_comb begin
    unique case (addr)
      REG_CTRL:   rdata = ctrl_rd;
      REG_RELOAD: rdata = DATA_W'(reload);
      REG_STATUS: rdata = DATA_W'(status);
      default:    rdata = DATA_W'(cnt);
    endcase
  end

  assign tick_irq    = status;
  assign tick_status = status;

  assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tick_irq);

endmodule

// File: tb/test_ptick_timer.sv
module test_ptick_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rtc_en = 1'b0;
  logic        ref_stb = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        tick_irq, tick_status;

  ptick_timer i_ptick_timer (
    .clk(clk), .rst_n(rst_n), .rtc_en(rtc_en), .ref_stb(ref_stb),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .tick_irq(tick_irq), .tick_status(tick_status)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // behavioural reference state
  int m_presc, m_cnt, m_reload, m_run, m_stat, m_ten, m_div;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int mask, pulse, expire, wc, start, stopw;
    int n_cnt, n_run, n_stat;
    cyc++;
    if (!rst_n) begin
      m_presc = 0; m_cnt = 0; m_reload = 0; m_run = 0;
      m_stat = 0; m_ten = 0; m_div = 0;
    end else begin
      mask   = (1 << m_div) - 1;
      pulse  = (rtc_en && ref_stb && ((m_presc & mask) == mask)) ? 1 : 0;
      expire = (m_run != 0 && pulse != 0 && m_cnt == 1) ? 1 : 0;
      wc     = (wr_en && addr == 2'd0) ? 1 : 0;
      start  = (wc != 0 && wdata[8] && m_ten == 0 && rtc_en && m_reload != 0) ? 1 : 0;
      stopw  = (wc != 0 && !wdata[8] && m_ten != 0 && rtc_en) ? 1 : 0;
      if (start != 0) n_cnt = m_reload;
      else if (m_run != 0 && pulse != 0) n_cnt = (m_cnt == 1) ? m_reload : m_cnt - 1;
      else n_cnt = m_cnt;
      if (!rtc_en) n_run = 0;
      else if (start != 0) n_run = 1;
      else if (stopw != 0) n_run = 0;
      else n_run = m_run;
      if (expire != 0) n_stat = 1;
      else if (wr_en && addr == 2'd2 && wdata[0]) n_stat = 0;
      else n_stat = m_stat;
      if (wc != 0) begin
        m_ten = int'(wdata[8]);
        m_div = int'(wdata[7:4]);
      end
      if (wr_en && addr == 2'd1 && wdata > 16'd2) m_reload = int'(wdata);
      if (!rtc_en) m_presc = 0;
      else if (ref_stb) m_presc = (m_presc + 1) % 32768;
      m_cnt = n_cnt; m_run = n_run; m_stat = n_stat;
    end
    #2;
    if (!done) begin
      chk("R6 tick_irq vs model", int'(tick_irq), m_stat);
      chk("R7 tick_status vs model", int'(tick_status), m_stat);
      case (addr)
        2'd0: chk("R12 control readback", int'(rdata), (m_ten << 8) | (m_div << 4));
        2'd1: chk("R3 reload readback", int'(rdata), m_reload);
        2'd2: chk("R7 status readback", int'(rdata), m_stat);
        default: chk("R11 live count", int'(rdata), m_cnt);
      endcase
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 16'd0;
  endtask

  task automatic sel(input logic [1:0] a);
    @(negedge clk);
    addr = a;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input string req);
    int guard = 0;
    while (!tick_irq && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (!tick_irq) chk(req, 0, 1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog R5 actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    int t0, v;
    idle(3);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      sel(2'(a));
      @(negedge clk);
      chk("R1 reset readback", int'(rdata), 0);
    end
    chk("R1 irq after reset", int'(tick_irq), 0);
    rtc_en = 1'b1; ref_stb = 1'b1;

    // R4: no start with zero reload
    wr(2'd0, 16'h0100);
    sel(2'd3); idle(10);
    chk("R4 no start with zero reload", int'(rdata), 0);
    chk("R4 no irq with zero reload", int'(tick_irq), 0);
    wr(2'd0, 16'h0000);

    // R3: reload floor
    wr(2'd1, 16'd2); sel(2'd1); @(negedge clk);
    chk("R3 reload 2 rejected", int'(rdata), 0);
    wr(2'd1, 16'd3); @(negedge clk);
    chk("R3 reload 3 accepted", int'(rdata), 3);
    wr(2'd1, 16'd1); @(negedge clk);
    chk("R3 reload 1 rejected", int'(rdata), 3);

    // R4: no start while globally disabled
    rtc_en = 1'b0;
    wr(2'd0, 16'h0100);
    rtc_en = 1'b1;
    sel(2'd3); idle(6);
    chk("R4 no start while rtc_en low", int'(rdata), 0);
    wr(2'd0, 16'h0000);

    // R2, R5: N=2, reload 5 -> 20 cycle period
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0120);
    sel(2'd3); @(negedge clk);
    chk("R4 start loads reload", int'(rdata) <= 5 && int'(rdata) >= 4 ? 1 : 0, 1);
    wait_irq("R6 first expiry N=2");
    t0 = cyc;
    wr(2'd2, 16'd1);
    chk("R7 write one clears", int'(tick_status), 0);
    wait_irq("R6 second expiry N=2");
    chk("R2 R5 period N=2 reload 5", cyc - t0, 20);
    wr(2'd2, 16'd0);
    chk("R7 write zero keeps flag", int'(tick_status), 1);

    // R5: N=0, reload 3 -> 3 cycle period
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0100);
    sel(2'd3);
    wait_irq("R6 first expiry N=0");
    t0 = cyc;
    wr(2'd2, 16'd1);
    wait_irq("R6 second expiry N=0");
    chk("R2 R5 period N=0 reload 3", cyc - t0, 3);

    // R8: clear in the expiry cycle
    idle(4);
    while (!(m_cnt == 1 && m_run != 0)) @(negedge clk);
    chk("R8 flag set before collision", int'(tick_status), 1);
    wr_en = 1'b1; addr = 2'd2; wdata = 16'd1;
    @(negedge clk);
    wr_en = 1'b0; wdata = 16'd0;
    chk("R8 expiry wins over clear", int'(tick_status), 1);

    // R9: stop holds count
    wr(2'd0, 16'h0000);
    sel(2'd3); @(negedge clk);
    v = int'(rdata);
    idle(7);
    chk("R9 count held after stop", int'(rdata), v);

    // R10: global disable stops, re-enable does not restart
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0100);
    sel(2'd3);
    rtc_en = 1'b0;
    @(negedge clk);
    v = int'(rdata);
    idle(6);
    chk("R10 count frozen while rtc_en low", int'(rdata), v);
    rtc_en = 1'b1;
    idle(8);
    chk("R10 no restart on rtc_en rise", int'(rdata), v);
    chk("R10 no irq without restart", int'(tick_irq), 0);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0100);
    sel(2'd3);
    wait_irq("R10 restart after fresh edge");
    chk("R6 irq after restart", int'(tick_irq), 1);

    // R12: control readback masks unused bits
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'hFFFF);
    sel(2'd0); @(negedge clk);
    chk("R12 control masked readback", int'(rdata), 16'h01F0);
    idle(4);
    finish_run();
  end

endmodule